// File: doc/BRIEF.md
# Commit-Point Trap Controller

This block decides when a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) takes a trap. Each stage can flag a fault for the instruction it holds. A fetch-address fault, an illegal opcode, an arithmetic overflow or a data-address fault is recorded in a small side pipeline. That side pipeline travels alongside the instruction's PC and valid bit. No fault has any effect until the instruction reaches the memory stage, which is the single commit point.

At the commit point the controller picks one cause. An external interrupt beats every synchronous fault. Among the synchronous faults, the one raised in the earliest stage wins. When a trap is taken, the controller does four things in the same cycle: it pulses a kill to all five stages, it suppresses the writeback of the trapping instruction, it drives a redirect with the handler address so that fetch starts there on the next cycle, and on the clock edge it loads the Cause and EPC registers. Younger instructions that are killed lose their pending fault flags.

Top module: `trap_ctl`

## Requirements
- R1: While reset is asserted, `kill` and `redirect` are 0, and `cause_q` and `epc_q` read 0.
- R2: Cause codes, held in `cause_q` zero-extended, are:
  - fetch-address fault = 1
  - illegal opcode = 2
  - overflow = 3
  - data-address fault = 4
  - interrupt = 8
- R3: A fault raised in fetch, decode or execute causes no trap until the instruction is valid in the memory stage. A fetch fault therefore traps three cycles after it is presented.
- R4: When one instruction collects faults in several stages, the cause of the earliest stage is recorded (fetch before decode before execute before memory).
- R5: `irq` is sampled only at the commit point. It traps with code 8 over any synchronous fault, and it has no effect when the memory stage holds no valid instruction.
- R6: On a trap, `epc_q` loads the PC of the instruction in the memory stage. The new value is visible after the clock edge.
- R7: In a trap cycle, `kill` is 5'b11111, `redirect` is 1 and `redirect_pc` equals `HANDLER_PC`. The kill bits map as: bit 0 fetch, bit 1 decode, bit 2 execute, bit 3 memory, bit 4 writeback. In the following cycle `kill` is 0 and `redirect` is 0.
- R8: Instructions in fetch, decode or execute during a trap cycle are discarded with their fault flags. They never cause a trap later.
- R9: `cause_q` and `epc_q` keep their values in every cycle without a trap.
- R10: A fault input raised for an empty (bubble) slot is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_valid | input | 1 | Fetch stage holds an instruction |
| f_pc | input | PC_W | PC of the fetch-stage instruction |
| f_pc_fault | input | 1 | Fetch-address fault for the fetch-stage instruction |
| d_illegal | input | 1 | Illegal opcode for the decode-stage instruction |
| e_overflow | input | 1 | Arithmetic overflow for the execute-stage instruction |
| m_data_fault | input | 1 | Data-address fault for the memory-stage instruction |
| irq | input | 1 | External interrupt request |
| kill | output | 5 | Per-stage kill pulse, bit 0 fetch to bit 4 writeback |
| redirect | output | 1 | Fetch must restart at `redirect_pc` next cycle |
| redirect_pc | output | PC_W | Handler address when `redirect` is 1, else 0 |
| cause_q | output | CAUSE_W | Cause register |
| epc_q | output | PC_W | Exception PC register |

## Verification
The bench runs every one of the 32 combinations of the four fault flags and the interrupt on an instruction that has only bubbles behind it. In those bubbles it drives every fault line and `irq` high. A design that does not qualify faults by slot validity, or that takes an interrupt with an empty commit stage, would trap in those bubbles. It then sends long back-to-back streams in which faulting instructions follow one another closely. A design that lets a killed instruction keep its flags would take a second trap one to three cycles later. A design that picks the latest cause instead of the earliest, or lets a synchronous fault beat the interrupt, would write the wrong code. Each trap is also checked for the exact one-cycle kill, the handler address and the EPC of the committing instruction.

// File: rtl/trap_ctl_pkg.sv
package trap_ctl_pkg;

  localparam int unsigned CODE_W = 4;

  localparam logic [CODE_W-1:0] CODE_NONE   = 4'd0;
  localparam logic [CODE_W-1:0] CODE_PCADDR = 4'd1;
  localparam logic [CODE_W-1:0] CODE_ILLOP  = 4'd2;
  localparam logic [CODE_W-1:0] CODE_OVF    = 4'd3;
  localparam logic [CODE_W-1:0] CODE_DADDR  = 4'd4;
  localparam logic [CODE_W-1:0] CODE_IRQ    = 4'd8;

  // number of pipeline stages and carried stage registers before commit
  localparam int unsigned N_STAGES   = 5;
  localparam int unsigned N_CARRY    = 3;

  // fault code raised by the stage that feeds carry register idx
  function automatic logic [CODE_W-1:0] carry_code(input int idx);
    case (idx)
      0:       return CODE_PCADDR;
      1:       return CODE_ILLOP;
      default: return CODE_OVF;
    endcase
  endfunction

endpackage

// File: rtl/trap_ctl_rst_sync.sv
module trap_ctl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/trap_ctl_stage.sv
// One carried pipeline register: valid, PC and the oldest pending fault.
module trap_ctl_stage
  import trap_ctl_pkg::*;
#(
  parameter int unsigned        PC_W       = 32,
  parameter logic [CODE_W-1:0]  LOCAL_CODE = CODE_PCADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [PC_W-1:0]   in_pc,
  input  logic              in_exc,
  input  logic [CODE_W-1:0] in_code,
  input  logic              local_fault,
  output logic              out_valid,
  output logic [PC_W-1:0]   out_pc,
  output logic              out_exc,
  output logic [CODE_W-1:0] out_code
);
  logic              valid_d, exc_d, pc_en;
  logic [CODE_W-1:0] code_d;
  logic              valid_q, exc_q;
  logic [CODE_W-1:0] code_q;
  logic [PC_W-1:0]   pc_q;

  always_comb begin
    valid_d = in_valid && !flush;
    exc_d   = valid_d && (in_exc || local_fault);
    code_d  = CODE_NONE;
    if (exc_d) begin
      // an older fault carried in wins over the one raised here
      code_d = in_exc ? in_code : LOCAL_CODE;
    end
    pc_en = valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      exc_q   <= 1'b0;
      code_q  <= CODE_NONE;
    end else begin
      valid_q <= valid_d;
      exc_q   <= exc_d;
      code_q  <= code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= in_pc;
  end

  assign out_valid = valid_q;
  assign out_pc    = pc_q;
  assign out_exc   = exc_q;
  assign out_code  = code_q;

  p_flush_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!out_valid && !out_exc));

  p_older_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_exc && !flush) |=> (out_exc && out_code == $past(in_code)));

  p_bubble_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_exc));

endmodule

// File: rtl/trap_ctl_arbiter.sv
// Commit-point decision: interrupt, then carried fault, then memory fault.
module trap_ctl_arbiter
  import trap_ctl_pkg::*;
(
  input  logic              m_valid,
  input  logic              m_exc,
  input  logic [CODE_W-1:0] m_code,
  input  logic              m_data_fault,
  input  logic              irq,
  output logic              take,
  output logic [CODE_W-1:0] take_code
);
  always_comb begin
    take      = m_valid && (irq || m_exc || m_data_fault);
    take_code = CODE_NONE;
    if (take) begin
      if (irq)               take_code = CODE_IRQ;
      else if (m_exc)        take_code = m_code;
      else                   take_code = CODE_DADDR;
    end
  end
endmodule

// File: rtl/trap_ctl_regs.sv
// Cause and EPC registers, loaded only in a trap cycle.
module trap_ctl_regs
  import trap_ctl_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned CAUSE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [CODE_W-1:0]  code,
  input  logic [PC_W-1:0]    pc,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [PC_W-1:0]    epc_q
);
  localparam int unsigned PAD_W = CAUSE_W - CODE_W;

  logic [CAUSE_W-1:0] cause_d;
  logic [PC_W-1:0]    epc_d;
  logic [CAUSE_W-1:0] cause_r;
  logic [PC_W-1:0]    epc_r;

  always_comb begin
    cause_d = {{PAD_W{1'b0}}, code};
    epc_d   = pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_r <= '0;
      epc_r   <= '0;
    end else if (load) begin
      cause_r <= cause_d;
      epc_r   <= epc_d;
    end
  end

  assign cause_q = cause_r;
  assign epc_q   = epc_r;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(cause_q) && $stable(epc_q)));

  p_epc_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (epc_q == $past(pc)));

  p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (code == CODE_PCADDR || code == CODE_ILLOP || code == CODE_OVF ||
              code == CODE_DADDR  || code == CODE_IRQ));

endmodule

// File: rtl/trap_ctl.sv
module trap_ctl
  import trap_ctl_pkg::*;
#(
  parameter int unsigned     PC_W       = 32,
  parameter int unsigned     CAUSE_W    = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 'h180
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                f_valid,
  input  logic [PC_W-1:0]     f_pc,
  input  logic                f_pc_fault,
  input  logic                d_illegal,
  input  logic                e_overflow,
  input  logic                m_data_fault,
  input  logic                irq,
  output logic [N_STAGES-1:0] kill,
  output logic                redirect,
  output logic [PC_W-1:0]     redirect_pc,
  output logic [CAUSE_W-1:0]  cause_q,
  output logic [PC_W-1:0]     epc_q
);
  localparam int unsigned LAST = N_CARRY;

  logic              rst_i_n;
  logic              take;
  logic [CODE_W-1:0] take_code;

  // index 0 is the fetch input; index LAST is the commit (memory) stage
  logic              st_valid [0:LAST];
  logic [PC_W-1:0]   st_pc    [0:LAST];
  logic              st_exc   [0:LAST];
  logic [CODE_W-1:0] st_code  [0:LAST];
  logic              raise    [0:LAST-1];

  trap_ctl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign st_valid[0] = f_valid;
  assign st_pc[0]    = f_pc;
  assign st_exc[0]   = 1'b0;
  assign st_code[0]  = CODE_NONE;

  assign raise[0] = f_pc_fault;
  assign raise[1] = d_illegal;
  assign raise[2] = e_overflow;

  for (genvar g = 0; g < LAST; g++) begin : g_carry
    trap_ctl_stage #(
      .PC_W       (PC_W),
      .LOCAL_CODE (carry_code(g))
    ) u_stage (
      .clk         (clk),
      .rst_n       (rst_i_n),
      .flush       (take),
      .in_valid    (st_valid[g]),
      .in_pc       (st_pc[g]),
      .in_exc      (st_exc[g]),
      .in_code     (st_code[g]),
      .local_fault (raise[g]),
      .out_valid   (st_valid[g+1]),
      .out_pc      (st_pc[g+1]),
      .out_exc     (st_exc[g+1]),
      .out_code    (st_code[g+1])
    );
  end

  trap_ctl_arbiter u_arb (
    .m_valid      (st_valid[LAST]),
    .m_exc        (st_exc[LAST]),
    .m_code       (st_code[LAST]),
    .m_data_fault (m_data_fault),
    .irq          (irq),
    .take         (take),
    .take_code    (take_code)
  );

  trap_ctl_regs #(
    .PC_W    (PC_W),
    .CAUSE_W (CAUSE_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .load    (take),
    .code    (take_code),
    .pc      (st_pc[LAST]),
    .cause_q (cause_q),
    .epc_q   (epc_q)
  );

  assign kill        = {N_STAGES{take}};
  assign redirect    = take;
  assign redirect_pc = take ? HANDLER_PC : '0;

  p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    redirect |=> (!redirect && kill == '0));

  p_commit_only_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    redirect |-> st_valid[LAST]);

  p_irq_wins_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (redirect && irq) |=> (cause_q == CAUSE_W'(CODE_IRQ)));

  p_early_wins_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (redirect && !irq && st_exc[LAST]) |=> (cause_q == CAUSE_W'($past(st_code[LAST]))));

endmodule

// File: tb/trap_ctl_bench.sv
module trap_ctl_bench;
  localparam int unsigned PC_W    = 32;
  localparam int unsigned CAUSE_W = 32;
  localparam logic [31:0] HANDLER = 32'h0000_0180;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, f_valid, f_pc_fault, d_illegal, e_overflow, m_data_fault, irq;
  logic [31:0] f_pc;
  logic [4:0]  kill;
  logic        redirect;
  logic [31:0] redirect_pc, cause_q, epc_q;

  trap_ctl #(.PC_W(PC_W), .CAUSE_W(CAUSE_W), .HANDLER_PC(HANDLER)) u_trap_ctl (
    .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .f_pc(f_pc),
    .f_pc_fault(f_pc_fault), .d_illegal(d_illegal), .e_overflow(e_overflow),
    .m_data_fault(m_data_fault), .irq(irq), .kill(kill), .redirect(redirect),
    .redirect_pc(redirect_pc), .cause_q(cause_q), .epc_q(epc_q));

  int n_chk = 0, n_fail = 0, cycles = 0;
  // plan bits: 0 fetch fault, 1 illegal, 2 overflow, 3 data fault, 4 irq at commit
  logic [4:0] plan [0:511];
  int sD = -1, sE = -1, sM = -1;
  logic [31:0] exp_cause = '0, exp_epc = '0;
  bit last_trap = 1'b0;
  int n_traps = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] pc_of(input int id);
    return 32'h0000_1000 + 32'(id) * 4;
  endfunction

  function automatic logic [31:0] code_of(input logic [4:0] m);
    if (m[4]) return 32'd8;
    if (m[0]) return 32'd1;
    if (m[1]) return 32'd2;
    if (m[2]) return 32'd3;
    if (m[3]) return 32'd4;
    return 32'd0;
  endfunction

  // one cycle: id < 0 is a bubble; noise drives fault lines of empty slots high
  task automatic step(input int id, input bit noise);
    bit exp_trap;
    logic [31:0] exp_code;
    @(negedge clk);
    if (last_trap) begin
      check(cause_q == exp_cause, "R2", "cause after trap", cause_q, exp_cause);
      check(epc_q == exp_epc, "R6", "epc after trap", epc_q, exp_epc);
    end else begin
      check(cause_q == exp_cause && epc_q == exp_epc, "R9", "cause held",
            cause_q, exp_cause);
    end
    f_valid      = (id >= 0);
    f_pc         = (id >= 0) ? pc_of(id) : 32'hDEAD_0000;
    f_pc_fault   = (id >= 0) ? plan[id][0] : noise;
    d_illegal    = (sD >= 0) ? plan[sD][1] : noise;
    e_overflow   = (sE >= 0) ? plan[sE][2] : noise;
    m_data_fault = (sM >= 0) ? plan[sM][3] : noise;
    irq          = (sM >= 0) ? plan[sM][4] : noise;
    #1;
    exp_trap = (sM >= 0) && (plan[sM] != 5'd0);
    exp_code = (sM >= 0) ? code_of(plan[sM]) : 32'd0;
    if (exp_trap) begin
      check(kill == 5'h1F, "R7", "kill all stages", {27'd0, kill}, 32'h1F);
      check(redirect && redirect_pc == HANDLER, "R7", "handler redirect",
            redirect_pc, HANDLER);
      if (last_trap)
        check(1'b0, "R7", "trap on consecutive cycle", 32'd1, 32'd0);
    end else begin
      check(kill == 5'h00 && !redirect, "R3 R8 R10", "no trap expected",
            {27'd0, kill}, 32'h0);
      if (last_trap)
        check(kill == 5'h00, "R7", "kill lasts one cycle", {27'd0, kill}, 32'h0);
    end
    @(posedge clk);
    cycles++;
    last_trap = exp_trap;
    if (exp_trap) begin
      n_traps++;
      exp_cause = exp_code;
      exp_epc   = pc_of(sM);
      sM = -1; sE = -1; sD = -1;
    end else begin
      sM = sE; sE = sD; sD = id;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) plan[i] = 5'd0;
    rst_n = 1'b0; f_valid = 0; f_pc = '0; f_pc_fault = 0; d_illegal = 0;
    e_overflow = 0; m_data_fault = 0; irq = 0;
    repeat (3) @(negedge clk);
    // R1: reset state, even with fault lines active
    f_valid = 1; f_pc_fault = 1; irq = 1; m_data_fault = 1;
    #1;
    check(kill == 5'h00 && !redirect, "R1", "kill/redirect in reset", {27'd0, kill}, 32'h0);
    check(cause_q == 32'd0, "R1", "cause in reset", cause_q, 32'd0);
    check(epc_q == 32'd0, "R1", "epc in reset", epc_q, 32'd0);
    f_valid = 0; f_pc_fault = 0; irq = 0; m_data_fault = 0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    @(posedge clk);

    // R2 R4 R5: every fault/interrupt combination on an isolated instruction,
    // followed by bubbles that drive all fault lines (R10, R5 empty commit)
    for (int m = 0; m < 32; m++) begin
      plan[m] = 5'(m);
      step(m, 1'b0);
      for (int b = 0; b < 4; b++) step(-1, 1'b1);
    end
    check(n_traps == 31, "R2", "trap count in sweep", 32'(n_traps), 32'd31);

    // R8 R4: back-to-back streams where younger faulting instructions get killed
    for (int i = 40; i < 300; i++) begin
      plan[i] = ((i % 3) == 0) ? 5'((i * 7) % 32) : 5'(((i * 5) % 11 == 0) ? 4 : 0);
      step(i, 1'b0);
      if ((i % 17) == 0) step(-1, 1'b1);
    end
    for (int b = 0; b < 4; b++) step(-1, 1'b0);

    // R3: fetch fault traps exactly three cycles later (checked per cycle above)
    plan[300] = 5'b00001;
    step(300, 1'b0);
    for (int b = 0; b < 4; b++) step(-1, 1'b0);
    check(exp_cause == 32'd1 && cause_q == 32'd1, "R3", "late fetch fault", cause_q, 32'd1);

    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule